// File: doc/BRIEF.md
# Prescaled Duty-Programmable Serial Clock Generator

This block derives a serial clock for an SPI shifter from the system clock. Two counters sit in series. A prescaler divides the system clock by a programmable factor `pre`. A period counter then steps once per prescaler tick through `n` counts. The serial clock is high for the first `h` counts of each period and low for the rest. The output frequency is therefore f_sys / (pre × n), and the duty cycle is about h/n. Every field is programmed as its value minus one, so `pre` spans 1 to 8192 and `n` and `h` span 1 to 64. Choosing the best `pre`/`n` pair is left to software.

The block drives three outputs: the clock level itself, and two one-cycle enable pulses that mark the rising and falling transitions, so that a shifter running on the system clock can pick its launch and capture edges. The programmed fields are sampled only at a period boundary, so a rewrite never makes a runt pulse. A bypass input routes the system clock straight to the output and holds the counters idle. All pins are plain control and status signals; the block has no streaming interface and no back-pressure.

Top module: `sclk_gen`

## Requirements
- R1: While reset is asserted, `sck_o`, `rise_en_o` and `fall_en_o` are all 0.
- R2: With bypass low, the serial clock period is (`pre_m1_i`+1) × (`period_m1_i`+1) system cycles. `pre_m1_i` is 13 bits wide and `period_m1_i` is 6 bits wide.
- R3: Each period begins with (`high_m1_i`+1) × (`pre_m1_i`+1) cycles of `sck_o`=1, followed by 0 for the rest of the period. If `high_m1_i` ≥ `period_m1_i`, `sck_o` stays 1.
- R4: `rise_en_o` is 1 for exactly the first cycle in which the registered level is newly 1. `fall_en_o` is 1 for exactly the first cycle in which it is newly 0. The two are never 1 together outside bypass.
- R5: Field values written in the middle of a period have no effect until that period ends. The next period then uses them in full.
- R6: While `bypass_i` is 1, `sck_o` equals `clk` and both enable outputs are held at 1, whatever the field values.
- R7: On the first clock edge after reset is released, or after `bypass_i` falls, the fields are sampled, the level goes to 1, and `rise_en_o` pulses; count 0 of the first period starts on that edge.
- R8: With `period_m1_i` = 0, the level stays 1 after the first edge, and no further enable pulses occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | 1 routes the system clock to `sck_o` |
| pre_m1_i | input | 13 | Prescaler divide factor minus one |
| period_m1_i | input | 6 | Counts per serial period minus one |
| high_m1_i | input | 6 | High counts per period minus one |
| sck_o | output | 1 | Serial clock level |
| rise_en_o | output | 1 | One-cycle pulse on a rising transition |
| fall_en_o | output | 1 | One-cycle pulse on a falling transition |

## Verification
A corrupted prescaler or period count shows up at the ports within one serial period as an edge pulse in the wrong cycle, so comparing all three outputs every cycle against a period-by-period model catches it within at most pre × n cycles. Shadow fields captured at the wrong moment show up as a period of the wrong length right after a mid-period rewrite. The bench therefore measures the period that follows such a rewrite, as well as the one after it. A level register that disagrees with its edge pulses appears as a missing or doubled pulse on the very cycle of the transition.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  localparam int unsigned PRE_W_DEF = 13;
  localparam int unsigned CNT_W_DEF = 6;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale #(
  parameter int unsigned PRE_W = sclk_gen_pkg::PRE_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt;

  assign tick = !clr && (pcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (clr)      pcnt <= '0;
    else if (tick)     pcnt <= '0;
    else               pcnt <= pcnt + PRE_W'(1);
  end

  AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (pcnt <= limit)); // R2
endmodule

// File: rtl/sclk_period.sv
module sclk_period #(
  parameter int unsigned CNT_W = sclk_gen_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next,
  output logic             wrap
);
  assign wrap = adv && (cnt == limit);

  always_comb begin
    if (clr)       cnt_next = '0;
    else if (wrap) cnt_next = '0;
    else if (adv)  cnt_next = cnt + CNT_W'(1);
    else           cnt_next = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt <= limit)); // R2
endmodule

// File: rtl/sclk_shape.sv
module sclk_shape #(
  parameter int unsigned CNT_W = sclk_gen_pkg::CNT_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic                start,
  input  logic [CNT_W-1:0]    cnt_next,
  input  logic [CNT_W-1:0]    high_lim,
  output logic                lvl,
  output sclk_gen_pkg::edge_t edges
);
  logic lvl_next;

  // count 0 is always high; later counts high while at or below the limit
  assign lvl_next = (cnt_next == '0) || (cnt_next <= high_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= 1'b0;
      edges <= '0;
    end else if (hold) begin
      lvl   <= 1'b0;
      edges <= '0;
    end else if (start) begin
      lvl        <= 1'b1;
      edges.rise <= !lvl;
      edges.fall <= 1'b0;
    end else begin
      lvl        <= lvl_next;
      edges.rise <= lvl_next && !lvl;
      edges.fall <= !lvl_next && lvl;
    end
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(edges.rise && edges.fall)); // R4
  AST_ROSE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl) |-> edges.rise); // R4
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned PRE_W = sclk_gen_pkg::PRE_W_DEF,
  parameter int unsigned CNT_W = sclk_gen_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass_i,
  input  logic [PRE_W-1:0] pre_m1_i,
  input  logic [CNT_W-1:0] period_m1_i,
  input  logic [CNT_W-1:0] high_m1_i,
  output logic             sck_o,
  output logic             rise_en_o,
  output logic             fall_en_o
);
  localparam int unsigned SHADOW_W = PRE_W + 2 * CNT_W;

  logic                start_q;
  logic                clr;
  logic                ptick;
  logic                wrap;
  logic                load;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    cnt_next;
  logic [PRE_W-1:0]    act_pre;
  logic [CNT_W-1:0]    act_per;
  logic [CNT_W-1:0]    act_high;
  logic                lvl_q;
  sclk_gen_pkg::edge_t edges;

  assign clr  = start_q || bypass_i;
  assign load = !bypass_i && (start_q || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b1;
    else        start_q <= bypass_i;
  end

  // shadow fields, refreshed only at a period boundary or a restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {act_pre, act_per, act_high} <= SHADOW_W'(0);
    end else if (load) begin
      act_pre  <= pre_m1_i;
      act_per  <= period_m1_i;
      act_high <= high_m1_i;
    end
  end

  sclk_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .limit (act_pre),
    .tick  (ptick)
  );

  sclk_period #(.CNT_W(CNT_W)) u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .adv      (ptick),
    .limit    (act_per),
    .cnt      (cnt),
    .cnt_next (cnt_next),
    .wrap     (wrap)
  );

  sclk_shape #(.CNT_W(CNT_W)) u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (bypass_i),
    .start    (start_q),
    .cnt_next (cnt_next),
    .high_lim (act_high),
    .lvl      (lvl_q),
    .edges    (edges)
  );

  assign sck_o     = bypass_i ? clk : lvl_q;
  assign rise_en_o = bypass_i | edges.rise;
  assign fall_en_o = bypass_i | edges.fall;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({act_pre, act_per, act_high})); // R5
  AST_COUNT0_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_q && !bypass_i && cnt == '0) |-> lvl_q); // R3
  AST_RESTART_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_i) |=> (lvl_q && edges.rise)); // R7
  AST_SINGLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_q && !bypass_i && act_per == '0) |-> (lvl_q && !edges.fall)); // R8
endmodule

// File: tb/test_sclk_gen.sv
module test_sclk_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byp = 1'b0;
  logic [12:0] pre_m1 = '0;
  logic [5:0]  per_m1 = 6'd1;
  logic [5:0]  high_m1 = '0;
  logic        sck, rise, fall;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_run = 0, m_lvl = 0, m_r = 0, m_f = 0;
  int m_p = 0, m_c = 0, a_pre = 1, a_n = 1, a_h = 1;

  always #(CLK_P/2) clk = ~clk;

  sclk_gen i_sclk_gen (
    .clk(clk), .rst_n(rst_n), .bypass_i(byp), .pre_m1_i(pre_m1),
    .period_m1_i(per_m1), .high_m1_i(high_m1),
    .sck_o(sck), .rise_en_o(rise), .fall_en_o(fall)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load_fields();
    a_pre = int'(pre_m1) + 1;
    a_n   = int'(per_m1) + 1;
    a_h   = int'(high_m1) + 1;
  endtask

  // advance one edge, update the reference, compare all outputs
  task automatic cyc(string tag);
    bit nl;
    @(posedge clk);
    if (byp) begin
      m_run = 0; m_lvl = 0; m_r = 0; m_f = 0;
    end else begin
      if (!m_run) begin
        load_fields(); m_p = 0; m_c = 0; m_run = 1; nl = 1;
      end else begin
        if (m_p == a_pre - 1) begin
          m_p = 0;
          if (m_c == a_n - 1) begin m_c = 0; load_fields(); end
          else m_c++;
        end else m_p++;
        nl = (m_c < a_h);
      end
      m_r = nl && !m_lvl;
      m_f = !nl && m_lvl;
      m_lvl = nl;
    end
    #1;
    if (byp) begin
      chk(sck == 1'b1 && rise && fall, "R6", {sck, rise, fall}, 3'b111);
      @(negedge clk); #1;
      chk(sck == 1'b0, "R6", sck, 0);
    end else begin
      chk({sck, rise, fall} == {m_lvl, m_r, m_f}, tag,
          {sck, rise, fall}, {m_lvl, m_r, m_f});
    end
  endtask

  task automatic restart(int p, int n, int h);
    byp = 1'b1; cyc("R6");
    pre_m1 = 13'(p - 1); per_m1 = 6'(n - 1); high_m1 = 6'(h - 1);
    byp = 1'b0;
    cyc("R7");
    chk(sck && rise, "R7", {sck, rise}, 2'b11);
  endtask

  // wait for the next rising pulse, then measure one full period
  task automatic measure(int ep, int eh, string tag);
    int per = 0, hi = 0, g = 0;
    while (!rise && g < 40000) begin cyc(tag); g++; end
    while (g < 40000) begin
      if (sck) hi++;
      per++; g++;
      cyc(tag);
      if (rise) break;
    end
    chk(per == ep, "R2", per, ep);
    chk(hi == eh, "R3", hi, eh);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({sck, rise, fall} == 3'b000, "R1", {sck, rise, fall}, 0);
    @(negedge clk);
    pre_m1 = 13'd2; per_m1 = 6'd4; high_m1 = 6'd1;
    rst_n = 1'b1;
    cyc("R7");
    chk(sck && rise, "R7", {sck, rise}, 2'b11);
    measure(15, 6, "R2");
    repeat (40) cyc("R4");

    restart(1, 2, 1);  measure(2, 1, "R2");
    restart(4, 6, 64); repeat (60) cyc("R3");
    chk(sck == 1'b1, "R3", sck, 1);
    restart(3, 1, 1);  repeat (30) cyc("R8");
    chk(sck && !rise && !fall, "R8", {sck, rise, fall}, 3'b100);
    restart(8192, 2, 1); measure(16384, 8192, "R2");

    // R6: fields ignored in bypass
    byp = 1'b1;
    for (int i = 0; i < 6; i++) begin
      pre_m1 = 13'($urandom_range(0, 20)); per_m1 = 6'($urandom);
      cyc("R6");
    end

    // R5: rewrite mid-period; old period finishes first
    restart(2, 4, 1);
    repeat (3) cyc("R5");
    pre_m1 = 13'd0; per_m1 = 6'd5; high_m1 = 6'd2;
    measure(6, 3, "R5");
    measure(6, 3, "R5");

    // random configurations, some rewritten mid-period
    for (int i = 0; i < 24; i++) begin
      restart($urandom_range(1, 8), $urandom_range(1, 64), $urandom_range(1, 64));
      for (int k = 0; k < 250; k++) begin
        if ($urandom_range(0, 99) == 0) begin
          pre_m1 = 13'($urandom_range(0, 7));
          per_m1 = 6'($urandom); high_m1 = 6'($urandom);
        end
        cyc("R5");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule